// File: doc/BRIEF.md
# SPI NOR Flash Command Sequencer

This block turns one request into a complete exchange with a serial NOR flash device on a single chip-select line. A request carries an operation code, a 24-bit byte address and a byte count. The block wraps every exchange in chip-select and drives the serial clock in mode 3: the clock idles high, output data changes on falling edges and input data is sampled on rising edges. Addressed operations send a single 32-bit header, MSB first, with the command byte on top and the address below it. Program and both erase operations are each preceded by their own write-enable exchange.

Write data enters one byte at a time through a valid/ready port while chip-select stays low. Each read byte is presented for one cycle on a byte-wide output. A program request that would cross a 256-byte page is cut short at the page end and the error output is raised. The controller is a single state machine with eight states:

- IDLE accepts a request. It moves to WEN_SHIFT for write-enable, program or erase, to CMD_SHIFT for read or status, and to END_GAP for an unsupported code.
- WEN_SHIFT sends the write-enable byte. It moves to END_GAP for a plain write-enable and to WEN_GAP otherwise.
- WEN_GAP holds chip-select high, then moves to CMD_SHIFT.
- CMD_SHIFT sends the header. It then moves to WR_FETCH (program bytes to send), RD_SHIFT (read bytes wanted) or END_GAP.
- WR_FETCH waits for a byte, then moves to WR_SHIFT.
- WR_SHIFT returns to WR_FETCH, or moves to END_GAP after the last byte.
- RD_SHIFT repeats until the last byte, then moves to END_GAP.
- END_GAP holds chip-select high, pulses `done` and returns to IDLE.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, spi_cs_n=1, spi_sck=1, req_ready=1, and rd_valid, done, err and wr_ready are all 0.
- R2: Operation code 0 (write-enable) produces exactly one chip-select frame of 8 clocks that carries the byte 0x06.
- R3: Mode 3 timing applies. spi_sck is high whenever spi_cs_n is high. spi_mosi changes only on falling edges of spi_sck. spi_miso is sampled on rising edges, MSB first.
- R4: Operation code 1 (page program) gives a first frame of 8 clocks carrying 0x06. A second frame follows with 0x02 and the 24-bit address, MSB first, then every accepted write byte MSB first. The second frame has 32+8N clocks in one unbroken chip-select low period.
- R5: Operation codes 4 and 5 send a write-enable frame, then one 32-clock frame. That frame carries 0x20 (4 KB erase) or 0xD8 (64 KB erase) followed by the address.
- R6: Operation code 2 (read) sends 0x03 and the address, then clocks req_len bytes. Each byte appears on rd_data with a one-cycle rd_valid pulse, in arrival order.
- R7: Operation code 3 (read status) sends the single byte 0x05 with no address, then clocks req_len bytes in the same way as a read.
- R8: A program accepts min(req_len, 256 - req_addr[7:0]) write bytes. err rises when that number is smaller than req_len, and stays set until the next request is accepted, which clears it. A request that exactly fills the page leaves err at 0.
- R9: spi_cs_n stays high for at least 2*HALF_DIV clock cycles (one SCK period) between any two frames, including the two frames of a program or erase.
- R10: req_ready is high only while idle. wr_ready is high only when a program byte is wanted, so read, status and erase consume no write bytes. done pulses once per request, after the last frame.
- R11: A read, status or program with req_len = 0 sends only its command (and address), then finishes.
- R12: Operation codes 6 and 7 produce no frame, set err and still pulse done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request taken on valid and ready |
| req_op | input | 3 | Operation code: 0 write-enable, 1 program, 2 read, 3 status, 4 erase 4 KB, 5 erase 64 KB |
| req_addr | input | 24 | Flash byte address |
| req_len | input | LEN_W | Byte count for program, read and status |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program byte offered |
| wr_ready | output | 1 | Program byte wanted |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| done | output | 1 | One-cycle pulse at the end of a request |
| err | output | 1 | Last request was truncated or unsupported |
| spi_cs_n | output | 1 | Flash chip-select, active low |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Data to flash |
| spi_miso | input | 1 | Data from flash |

## Verification
The hardest situation to reach from the ports is a program request that runs into the page end part-way through. It needs an address near the top of a page and a length that passes the end. The bench then has to count the write handshakes the controller accepts, not the bytes it was offered. The bench issues a program at page offset 0xF0 with 40 bytes and expects 16 handshakes, a 160-clock data frame and err set. Next it checks that a following write-enable clears err. Finally it fills a page from offset 0 with exactly 256 bytes to confirm the boundary case does not raise err.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [2:0] {
        OP_WREN  = 3'd0,
        OP_PROG  = 3'd1,
        OP_READ  = 3'd2,
        OP_STAT  = 3'd3,
        OP_ER4K  = 3'd4,
        OP_ER64K = 3'd5
    } flash_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WEN_SHIFT,
        ST_WEN_GAP,
        ST_CMD_SHIFT,
        ST_WR_FETCH,
        ST_WR_SHIFT,
        ST_RD_SHIFT,
        ST_END_GAP
    } seq_state_e;

    localparam logic [7:0] CMD_WREN  = 8'h06;
    localparam logic [7:0] CMD_PROG  = 8'h02;
    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam logic [7:0] CMD_STAT  = 8'h05;
    localparam logic [7:0] CMD_ER4K  = 8'h20;
    localparam logic [7:0] CMD_ER64K = 8'hD8;

    function automatic logic [7:0] op_to_cmd(input flash_op_e op);
        case (op)
            OP_PROG:  return CMD_PROG;
            OP_READ:  return CMD_READ;
            OP_STAT:  return CMD_STAT;
            OP_ER4K:  return CMD_ER4K;
            OP_ER64K: return CMD_ER64K;
            default:  return CMD_WREN;
        endcase
    endfunction

endpackage

// File: rtl/flash_spi_shifter.sv
module flash_spi_shifter #(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [5:0]  nbits,
    input  logic [31:0] word,
    input  logic        miso,
    output logic        done,
    output logic [7:0]  rx_byte,
    output logic        sck,
    output logic        mosi
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

    logic          busy_q;
    logic          sck_q;
    logic          done_q;
    logic [31:0]   shreg_q;
    logic [5:0]    left_q;
    logic [DW-1:0] div_q;
    logic [7:0]    rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            sck_q   <= 1'b1;
            done_q  <= 1'b0;
            shreg_q <= '0;
            left_q  <= '0;
            div_q   <= '0;
            rx_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                busy_q  <= 1'b1;
                sck_q   <= 1'b0;
                shreg_q <= word;
                left_q  <= nbits;
                div_q   <= '0;
            end else if (busy_q) begin
                if (div_q == DIV_LAST) begin
                    div_q <= '0;
                    if (!sck_q) begin
                        sck_q  <= 1'b1;
                        rx_q   <= {rx_q[6:0], miso};
                        left_q <= left_q - 6'd1;
                    end else if (left_q == 6'd0) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        sck_q   <= 1'b0;
                        shreg_q <= {shreg_q[30:0], 1'b0};
                    end
                end else begin
                    div_q <= div_q + DW'(1);
                end
            end
        end
    end

    assign done    = done_q;
    assign rx_byte = rx_q;
    assign sck     = sck_q;
    assign mosi    = shreg_q[31];

    AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(sck_q) |-> $stable(shreg_q[31])); // R3
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q); // R4

endmodule

// File: rtl/flash_cs_gap.sv
module flash_cs_gap #(
    parameter int GAP_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(GAP_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign expired = run && (cnt_q == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || expired)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CW'(1);
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int HALF_DIV   = 2,
    parameter int PAGE_BYTES = 256,
    parameter int LEN_W      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_op,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             done,
    output logic             err,
    output logic             spi_cs_n,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    localparam int PG_W    = $clog2(PAGE_BYTES);
    localparam int GAP_CYC = 2 * HALF_DIV;

    seq_state_e       state_q, state_d;
    flash_op_e        op_q;
    logic [23:0]      addr_q;
    logic [LEN_W-1:0] rem_q;
    logic             err_q;
    logic             launched_q;
    logic [7:0]       rd_data_q;
    logic             rd_valid_q;

    logic             eng_start, eng_done, gap_run, gap_exp;
    logic [5:0]       eng_bits;
    logic [31:0]      eng_word;
    logic [7:0]       eng_rx;

    logic             accept;
    logic [LEN_W-1:0] room, len_eff;
    logic             trunc, bad_op;

    assign accept  = req_valid && (state_q == ST_IDLE);
    assign room    = LEN_W'(PAGE_BYTES) - LEN_W'(req_addr[PG_W-1:0]);
    assign trunc   = (req_op == OP_PROG) && (req_len > room);
    assign len_eff = trunc ? room : req_len;
    assign bad_op  = (req_op > OP_ER64K);

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            op_q       <= OP_WREN;
            addr_q     <= '0;
            rem_q      <= '0;
            err_q      <= 1'b0;
            launched_q <= 1'b0;
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            launched_q <= eng_done ? 1'b0 : (launched_q | eng_start);
            rd_valid_q <= (state_q == ST_RD_SHIFT) && eng_done;
            if (accept) begin
                op_q   <= flash_op_e'(req_op);
                addr_q <= req_addr;
                rem_q  <= len_eff;
                err_q  <= trunc || bad_op;
            end
            if ((state_q == ST_WR_SHIFT || state_q == ST_RD_SHIFT) && eng_done)
                rem_q <= rem_q - LEN_W'(1);
            if ((state_q == ST_RD_SHIFT) && eng_done)
                rd_data_q <= eng_rx;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                case (req_op)
                    OP_READ, OP_STAT:                   state_d = ST_CMD_SHIFT;
                    OP_WREN, OP_PROG, OP_ER4K, OP_ER64K: state_d = ST_WEN_SHIFT;
                    default:                            state_d = ST_END_GAP;
                endcase
            end
            ST_WEN_SHIFT: if (eng_done)
                state_d = (op_q == OP_WREN) ? ST_END_GAP : ST_WEN_GAP;
            ST_WEN_GAP: if (gap_exp) state_d = ST_CMD_SHIFT;
            ST_CMD_SHIFT: if (eng_done) begin
                if (rem_q == '0 || op_q == OP_ER4K || op_q == OP_ER64K)
                    state_d = ST_END_GAP;
                else if (op_q == OP_PROG)
                    state_d = ST_WR_FETCH;
                else
                    state_d = ST_RD_SHIFT;
            end
            ST_WR_FETCH: if (wr_valid) state_d = ST_WR_SHIFT;
            ST_WR_SHIFT: if (eng_done)
                state_d = (rem_q == LEN_W'(1)) ? ST_END_GAP : ST_WR_FETCH;
            ST_RD_SHIFT: if (eng_done)
                state_d = (rem_q == LEN_W'(1)) ? ST_END_GAP : ST_RD_SHIFT;
            ST_END_GAP: if (gap_exp) state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        wr_ready  = (state_q == ST_WR_FETCH);
        gap_run   = (state_q == ST_WEN_GAP) || (state_q == ST_END_GAP);
        spi_cs_n  = (state_q == ST_IDLE) || gap_run;
        done      = (state_q == ST_END_GAP) && gap_exp;
        eng_start = 1'b0;
        eng_bits  = 6'd8;
        eng_word  = '0;
        unique case (state_q)
            ST_WEN_SHIFT: begin
                eng_start = !launched_q;
                eng_word  = {CMD_WREN, 24'h0};
            end
            ST_CMD_SHIFT: begin
                eng_start = !launched_q;
                if (op_q == OP_STAT) begin
                    eng_word = {CMD_STAT, 24'h0};
                end else begin
                    eng_word = {op_to_cmd(op_q), addr_q};
                    eng_bits = 6'd32;
                end
            end
            ST_WR_FETCH: begin
                eng_start = wr_valid;
                eng_word  = {wr_data, 24'h0};
            end
            ST_RD_SHIFT: eng_start = !launched_q;
            default: ;
        endcase
    end

    assign rd_data  = rd_data_q;
    assign rd_valid = rd_valid_q;
    assign err      = err_q;

    flash_spi_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .nbits   (eng_bits),
        .word    (eng_word),
        .miso    (spi_miso),
        .done    (eng_done),
        .rx_byte (eng_rx),
        .sck     (spi_sck),
        .mosi    (spi_mosi)
    );

    flash_cs_gap #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (gap_run),
        .expired (gap_exp)
    );

    AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> spi_sck); // R3
    AST_SCK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_sck) |-> !spi_cs_n); // R4
    AST_NO_PAGE_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (rem_q != '0)); // R8
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (spi_cs_n && !wr_ready)); // R10
    AST_DONE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (spi_cs_n && $past(spi_cs_n))); // R9
    AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R6

endmodule

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
    localparam int HALF_DIV = 2;
    localparam int LEN_W    = 10;
    localparam int GAP_CYC  = 2 * HALF_DIV;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [2:0]       req_op = '0;
    logic [23:0]      req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [7:0]       wr_data;
    logic             wr_valid = 1'b1;
    logic             wr_ready;
    logic [7:0]       rd_data;
    logic             rd_valid;
    logic             done;
    logic             err;
    logic             spi_cs_n, spi_sck, spi_mosi;
    logic             spi_miso = 1'b0;

    always #2 clk = ~clk;

    flash_cmd_seq #(.HALF_DIV(HALF_DIV), .PAGE_BYTES(256), .LEN_W(LEN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .err(err),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int errors = 0, checks = 0, cycles = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] wpat(input int i);
        return 8'(i) ^ 8'hA5;
    endfunction
    function automatic logic [7:0] rpat(input int j);
        return 8'(j * 29 + 60);
    endfunction

    // write data source
    int widx = 0;
    assign wr_data = wpat(widx);
    always @(posedge clk) if (wr_ready && wr_valid) widx <= widx + 1;

    // read capture
    logic [7:0] rbuf [0:15];
    int ridx = 0;
    always @(posedge clk) if (rd_valid) begin
        if (ridx < 16) rbuf[ridx] = rd_data;
        ridx++;
    end

    // flash line monitor
    logic [7:0] fbyte [0:3][0:299];
    int fbits [0:3];
    int nfr = 0, bitcnt = 0, cmd_len = 4;
    logic [7:0] sh = '0;
    always @(negedge spi_cs_n) begin
        bitcnt = 0;
        chk(spi_sck == 1'b1, "R3 sck high at cs fall", spi_sck, 1);
    end
    always @(posedge spi_cs_n) begin
        if (nfr < 4) fbits[nfr] = bitcnt;
        nfr++;
    end
    always @(posedge spi_sck) if (!spi_cs_n) begin
        sh = {sh[6:0], spi_mosi};
        bitcnt++;
        if (bitcnt % 8 == 0 && nfr < 4 && bitcnt / 8 <= 300) fbyte[nfr][bitcnt/8-1] = sh;
    end
    always @(negedge spi_sck) if (!spi_cs_n) begin
        int j;
        j = bitcnt / 8 - cmd_len;
        spi_miso = (j < 0) ? 1'b0 : rpat(j)[7 - bitcnt % 8];
    end

    // chip-select gap monitor
    int hi_cnt = 1000;
    logic cs_prev = 1'b1;
    always @(posedge clk) begin
        if (spi_cs_n) hi_cnt++;
        else if (cs_prev) begin
            chk(hi_cnt >= GAP_CYC, "R9 cs high gap", hi_cnt, GAP_CYC);
            hi_cnt = 0;
        end
        cs_prev = spi_cs_n;
    end

    task automatic run_op(input logic [2:0] op, input logic [23:0] addr, input int len, input int clen);
        int guard;
        @(negedge clk);
        nfr = 0; widx = 0; ridx = 0; cmd_len = clen;
        req_op = op; req_addr = addr; req_len = LEN_W'(len); req_valid = 1'b1;
        @(posedge clk);
        while (!req_ready) @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10 ready low while busy", req_ready, 0);
        guard = 0;
        while (!done && guard < 40000) begin @(posedge clk); guard++; end
        chk(guard < 40000, "R10 done pulse", guard, 0);
        @(negedge clk);
        chk(done == 1'b0, "R10 done single pulse", done, 0);
    endtask

    task automatic check_wren_frame(input string req);
        chk(fbits[0] == 8, req, fbits[0], 8);
        chk(fbyte[0][0] == 8'h06, req, fbyte[0][0], 8'h06);
    endtask

    task automatic check_hdr(input int f, input logic [7:0] c, input logic [23:0] a, input string req);
        chk(fbyte[f][0] == c, req, fbyte[f][0], c);
        chk({fbyte[f][1], fbyte[f][2], fbyte[f][3]} == a, req, {fbyte[f][1], fbyte[f][2], fbyte[f][3]}, a);
    endtask

    task automatic t_reset;
        chk(spi_cs_n == 1 && spi_sck == 1, "R1 idle lines", {spi_cs_n, spi_sck}, 2'b11);
        chk(req_ready == 1, "R1 ready", req_ready, 1);
        chk({rd_valid, done, err, wr_ready} == 4'b0, "R1 outputs low", {rd_valid, done, err, wr_ready}, 0);
    endtask

    task automatic t_wren;
        run_op(3'd0, 24'h0, 0, 4);
        chk(nfr == 1, "R2 frame count", nfr, 1);
        check_wren_frame("R2 wren frame");
        chk(err == 0, "R2 no error", err, 0);
    endtask

    task automatic t_program(input logic [23:0] a, input int len, input int exp_n, input bit exp_err, input string req);
        bit ok;
        run_op(3'd1, a, len, 4);
        chk(nfr == 2, {req, " frames"}, nfr, 2);
        check_wren_frame("R4 leading wren");
        check_hdr(1, 8'h02, a, "R4 program header");
        chk(fbits[1] == 32 + 8 * exp_n, {req, " data clocks"}, fbits[1], 32 + 8 * exp_n);
        chk(widx == exp_n, {req, " bytes accepted"}, widx, exp_n);
        ok = 1;
        for (int i = 0; i < exp_n; i++) if (fbyte[1][4+i] != wpat(i)) ok = 0;
        chk(ok, "R4 data bytes MSB first", ok, 1);
        chk(err == exp_err, {req, " err"}, err, exp_err);
    endtask

    task automatic t_erase(input logic [2:0] op, input logic [7:0] c, input logic [23:0] a);
        run_op(op, a, 3, 4);
        chk(nfr == 2, "R5 frames", nfr, 2);
        check_wren_frame("R5 leading wren");
        chk(fbits[1] == 32, "R5 erase clocks", fbits[1], 32);
        check_hdr(1, c, a, "R5 erase header");
        chk(widx == 0, "R10 erase takes no write bytes", widx, 0);
    endtask

    task automatic t_read(input logic [23:0] a, input int len);
        bit ok;
        run_op(3'd2, a, len, 4);
        chk(nfr == 1, "R6 frames", nfr, 1);
        chk(fbits[0] == 32 + 8 * len, "R6 read clocks", fbits[0], 32 + 8 * len);
        check_hdr(0, 8'h03, a, "R6 read header");
        chk(ridx == len, "R6 byte strobes", ridx, len);
        ok = 1;
        for (int i = 0; i < len && i < 16; i++) if (rbuf[i] != rpat(i)) ok = 0;
        chk(ok, "R3 R6 rising-edge capture", ok, 1);
        chk(widx == 0, "R10 read takes no write bytes", widx, 0);
    endtask

    task automatic t_status;
        run_op(3'd3, 24'hFFFFFF, 2, 1);
        chk(nfr == 1 && fbits[0] == 24, "R7 status clocks", fbits[0], 24);
        chk(fbyte[0][0] == 8'h05, "R7 status opcode", fbyte[0][0], 8'h05);
        chk(ridx == 2 && rbuf[0] == rpat(0) && rbuf[1] == rpat(1), "R7 status bytes", rbuf[1], rpat(1));
    endtask

    task automatic t_zero;
        run_op(3'd2, 24'h000123, 0, 4);
        chk(nfr == 1 && fbits[0] == 32, "R11 zero read header only", fbits[0], 32);
        chk(ridx == 0, "R11 zero read no bytes", ridx, 0);
        run_op(3'd1, 24'h000040, 0, 4);
        chk(nfr == 2 && fbits[1] == 32 && widx == 0, "R11 zero program header only", fbits[1], 32);
    endtask

    task automatic t_bad_op;
        run_op(3'd7, 24'h0, 4, 4);
        chk(nfr == 0, "R12 no frame", nfr, 0);
        chk(err == 1, "R12 err set", err, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_wren;
        t_program(24'h012340, 5, 5, 0, "R4 program");
        t_erase(3'd4, 8'h20, 24'hABCDEF);
        t_erase(3'd5, 8'hD8, 24'h100000);
        t_read(24'h00FF00, 4);
        t_status;
        t_program(24'h0000F0, 40, 16, 1, "R8 truncated");
        t_wren;
        chk(err == 0, "R8 err cleared by next request", err, 0);
        t_program(24'h000200, 256, 256, 0, "R8 full page");
        t_zero;
        t_bad_op;
        t_wren;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule